// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is a W-bit integer adder/subtractor. It carries out one of four operations on two operands: add, add with carry, subtract and subtract with carry. It drives the result combinationally. It also keeps four condition flags in an internal register: negative, zero, carry and overflow. The carry input to the chained operations is the stored carry flag, so multi-word arithmetic is done by issuing the low word first and the higher words after it.

Subtraction treats carry as "no borrow". After a subtract, a set carry means the minuend was not smaller than the subtrahend. Subtract with carry removes one extra unit when the stored carry is clear. The flag register loads only on a clock edge where the valid strobe is high. At all other times it holds its value.

Top module: `addsub_flag_alu`

## Requirements
- R1: With op=2'b00 (add), result equals opA+opB modulo 2^W. With op=2'b01 (add with carry), result equals opA+opB plus the stored carry flag.
- R2: With op=2'b10 (subtract), result equals opA-opB modulo 2^W. With op=2'b11 (subtract with carry), result equals opA-opB-1 when the stored carry is 0, and opA-opB when it is 1.
- R3: For add, the new carry is 1 exactly when result is unsigned-less than opA. For add with carry and stored carry 1, it is 1 exactly when result is unsigned-less-or-equal to opA.
- R4: For subtract, and for subtract with carry when the stored carry is 1, the new carry is 1 exactly when opA is unsigned greater than or equal to opB. For subtract with carry when the stored carry is 0, it is 1 exactly when opA is unsigned greater than opB.
- R5: For the add operations, overflow is set when opA and opB have equal sign bits and the result sign differs from them. For the subtract operations, it is set when the operand signs differ and the result sign differs from opA.
- R6: The negative flag takes bit W-1 of the result. The zero flag is set when every result bit is 0.
- R7: The flags change only at a rising clock edge where valid is 1. While valid is 0, they hold their values whatever op and the operands do.
- R8: An active-low reset, rstN, clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Load the flags from the current operation |
| op | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| result | output | W | Operation result, combinational |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagC | output | 1 | Stored carry / no-borrow flag |
| flagV | output | 1 | Stored signed overflow flag |

## Verification
The hardest cases to reach are the chained operations at their carry boundaries. One is subtract with carry on equal operands while the stored carry is clear: the result is all ones and the carry stays clear. The other is add with carry of an all-ones operand while the stored carry is set: the result equals opA and the carry is set. Neither can be driven directly, because the carry only gets into the block through an earlier operation. The stimulus table therefore places the operations in an order where each earlier one leaves the carry needed by the next. The bench tracks the flags in its own model so that every chained operation is predicted.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } opT;

  // Strobes from control to datapath
  typedef struct packed {
    logic invertB;        // feed ~opB to the adder
    logic carryFromFlag;  // carry-in taken from stored C
    logic carryConst;     // carry-in value when not from flag
    logic loadFlags;      // update flag register this cycle
  } strobeT;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flagsT;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op,
  output strobeT     strobes
);
  opT opSel;
  assign opSel = opT'(op);

  always_comb begin
    strobes = '0;
    strobes.loadFlags = valid;
    unique case (opSel)
      OP_ADD: begin
        strobes.invertB = 1'b0; strobes.carryFromFlag = 1'b0; strobes.carryConst = 1'b0;
      end
      OP_ADC: begin
        strobes.invertB = 1'b0; strobes.carryFromFlag = 1'b1; strobes.carryConst = 1'b0;
      end
      OP_SUB: begin
        strobes.invertB = 1'b1; strobes.carryFromFlag = 1'b0; strobes.carryConst = 1'b1;
      end
      OP_SBC: begin
        strobes.invertB = 1'b1; strobes.carryFromFlag = 1'b1; strobes.carryConst = 1'b0;
      end
      default: strobes.invertB = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output flagsT        flags
);
  localparam int SW = W + 1;
  localparam int MSB = W - 1;

  flagsT        flagReg;
  flagsT        flagNext;
  logic [W-1:0] bOperand;
  logic         carryIn;
  logic [SW-1:0] sumWide;

  // Subtract is a + ~b + cin; carry-out then means "no borrow"
  assign bOperand = strobes.invertB ? ~opB : opB;
  assign carryIn  = strobes.carryFromFlag ? flagReg.c : strobes.carryConst;
  assign sumWide  = {1'b0, opA} + {1'b0, bOperand} + SW'(carryIn);
  assign result   = sumWide[W-1:0];

  always_comb begin
    flagNext.n = sumWide[MSB];
    flagNext.z = (sumWide[W-1:0] == '0);
    flagNext.c = sumWide[W];
    flagNext.v = (opA[MSB] == bOperand[MSB]) && (sumWide[MSB] != opA[MSB]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
    end else if (strobes.loadFlags) begin
      flagReg <= flagNext;
    end
  end

  assign flags = flagReg;
endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV
);
  strobeT strobes;
  flagsT  flags;

  addsub_ctrl u_ctrl (
    .valid   (valid),
    .op      (op),
    .strobes (strobes)
  );

  addsub_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flags   (flags)
  );

  assign flagN = flags.n;
  assign flagZ = flags.z;
  assign flagC = flags.c;
  assign flagV = flags.v;
endmodule

// File: rtl/addsub_flag_alu_chk.sv
module addsub_flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         valid,
  input logic [1:0]   op,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] result,
  input logic         flagN,
  input logic         flagZ,
  input logic         flagC,
  input logic         flagV
);
  a_r1_add_result: assert property (@(posedge clk) disable iff (!rstN)
    (op == 2'b00) |-> (result == opA + opB));

  a_r2_sub_result: assert property (@(posedge clk) disable iff (!rstN)
    (op == 2'b10) |-> (result == opA - opB));

  a_r3_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    (valid && op == 2'b00) |=> (flagC == ($past(result) < $past(opA))));

  a_r4_sub_carry: assert property (@(posedge clk) disable iff (!rstN)
    (valid && op == 2'b10) |=> (flagC == ($past(opA) >= $past(opB))));

  a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> (flagN == $past(result[W-1])));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> (flagZ == ($past(result) == '0)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(flagN) && $stable(flagZ) && $stable(flagC) && $stable(flagV)));

  always @(posedge clk) begin
    if (!rstN) begin
      a_r8_reset_clear: assert (!flagN && !flagZ && !flagC && !flagV);
    end
  end
endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .valid(valid), .op(op), .opA(opA), .opB(opB),
  .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
);

// File: tb/addsub_flag_alu_test.sv
`timescale 1ns/1ps
module addsub_flag_alu_test;
  localparam int W = 32;

  typedef struct packed {
    logic [1:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } vecT;

  // Ordered so each entry leaves the carry the next one needs
  localparam int NV = 14;
  localparam vecT vecs [NV] = '{
    '{2'b00, 32'h0000_0005, 32'h0000_0003},   // add, C->0
    '{2'b01, 32'h0000_0010, 32'h0000_0001},   // adc with C=0
    '{2'b00, 32'hFFFF_FFFF, 32'h0000_0001},   // add wraps, C->1, Z
    '{2'b01, 32'h1234_5678, 32'hFFFF_FFFF},   // adc C=1, result==a, C->1
    '{2'b01, 32'h7FFF_FFFF, 32'h0000_0000},   // adc C=1 -> signed overflow
    '{2'b10, 32'h0000_0003, 32'h0000_0003},   // sub equal, C->1, Z
    '{2'b10, 32'h0000_0001, 32'h0000_0002},   // sub borrow, C->0, N
    '{2'b11, 32'h0000_0007, 32'h0000_0007},   // sbc C=0 equal -> all ones, C->0
    '{2'b11, 32'h0000_0009, 32'h0000_0004},   // sbc C=0, a>b, C->1
    '{2'b11, 32'h0000_0009, 32'h0000_0009},   // sbc C=1 equal -> 0, C->1
    '{2'b10, 32'h8000_0000, 32'h0000_0001},   // sub signed overflow
    '{2'b00, 32'h8000_0000, 32'h8000_0000},   // add neg overflow, C->1
    '{2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF},   // sub overflow pos-neg
    '{2'b01, 32'h4000_0000, 32'h4000_0000}    // adc C=0, overflow
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         valid = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result;
  logic         flagN, flagZ, flagC, flagV;

  int checks = 0;
  int fails = 0;
  logic mN = 1'b0, mZ = 1'b0, mC = 1'b0, mV = 1'b0;

  always #2.5 clk = ~clk;

  addsub_flag_alu #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .valid(valid), .op(op), .opA(opA), .opB(opB),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req, input logic n, input logic z, input logic c, input logic v);
    check(req, {28'd0, flagN, flagZ, flagC, flagV}, {28'd0, n, z, c, v});
  endtask

  // Model from the requirement wording: comparisons, not an adder chain
  task automatic model(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] r, output logic cN);
    case (o)
      2'b00: begin r = a + b; cN = (r < a); end
      2'b01: if (mC) begin r = a + b + 1; cN = (r <= a); end
             else begin r = a + b; cN = (r < a); end
      2'b10: begin r = a - b; cN = (a >= b); end
      default: if (mC) begin r = a - b; cN = (a >= b); end
               else begin r = a - b - 1; cN = (a > b); end
    endcase
  endtask

  task automatic runOp(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic cN, vN;
    @(negedge clk);
    op = o; opA = a; opB = b; valid = 1'b1;
    model(o, a, b, r, cN);
    if (o[1] == 1'b0) vN = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    else              vN = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    #1;
    check(o[1] ? "R2 result" : "R1 result", result, r);
    @(posedge clk);
    #1;
    valid = 1'b0;
    mN = r[W-1]; mZ = (r == '0); mC = cN; mV = vN;
    checkFlags(o[1] ? "R4 R5 R6 flags" : "R3 R5 R6 flags", mN, mZ, mC, mV);
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (2) @(posedge clk);
    #1;
    checkFlags("R8 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runOp(vecs[i].op, vecs[i].a, vecs[i].b);
    end

    // R7: valid low with an operation that would change every flag
    runOp(2'b00, 32'h8000_0000, 32'h8000_0000);   // N0 Z1 C1 V1
    @(negedge clk);
    op = 2'b10; opA = 32'h0000_0001; opB = 32'h0000_0002; valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkFlags("R7 hold while idle", mN, mZ, mC, mV);
    // stored carry unchanged: adc result still uses C=1
    #1;
    op = 2'b01; opA = 32'h0000_0001; opB = 32'h0000_0001;
    #1;
    check("R7 R1 carry kept", result, 32'h0000_0003);

    // R3 boundary: adc with C=1 and b all ones, carry from <=
    runOp(2'b01, 32'h0000_0000, 32'hFFFF_FFFF);

    // R8: reset clears flags set by the previous ops
    runOp(2'b10, 32'h0000_0000, 32'h0000_0001);   // N1 C0
    runOp(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // N1 C1
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkFlags("R8 async clear", 1'b0, 1'b0, 1'b0, 1'b0);
    mN = 1'b0; mZ = 1'b0; mC = 1'b0; mV = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    runOp(2'b11, 32'h0000_0005, 32'h0000_0005);   // sbc after reset, C=0

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule